// File: doc/BRIEF.md
# Atomic Access Attribute Checker

This block decides whether a conditional-store (compare-and-swap style) atomic access to a translated address may go ahead. For each request it combines four inputs: the result code of the address translation, the read and write rights of the page, the cache attribute of the page and a 6-bit atomic policy word. It returns either an accept or an exception with a 4-bit cause code.

The policy word holds one 2-bit field for each cacheable kind of page. The cache attribute of the page picks the field that is checked. An isolate page always faults. A configuration bit says whether a data cache exists. When it is clear, every page is handled as uncached.

Only one cause is reported per request. A translation fault comes first, then missing rights, then the attribute and policy check. The verdict is registered and appears as a one-cycle valid pulse on the clock after the request strobe.

Top module: `aac_checker`

## Requirements
- R1: A request (req_i high at a rising edge) produces rsp_valid_o high for exactly the following cycle. With no request, rsp_valid_o, rsp_accept_o and rsp_cause_o are all 0 in the following cycle. Synchronous active-high reset clears all three outputs.
- R2: A nonzero xlat_code_i rejects the request with rsp_cause_o equal to xlat_code_i, whatever the rights, attribute and policy inputs are.
- R3: When xlat_code_i is 0 and perm_rd_i and perm_wr_i are not both 1, the request is rejected with cause 4'hD (store-prohibited), ahead of any attribute check. This includes isolate pages. No load-type cause is ever produced.
- R4: With dcache_en_i = 1, the attribute codes select policy fields as follows: 3'd0 (uncached) selects pol_i[1:0], 3'd1 (write-through) selects pol_i[3:2] and 3'd2 (write-back) selects pol_i[5:4]. A selected field of 0 rejects with cause 4'h3 (load/store error). A nonzero field accepts.
- R5: With dcache_en_i = 1, attribute 3'd3 (isolate) always rejects with cause 4'h3, whatever pol_i holds.
- R6: With dcache_en_i = 0, every attribute code, isolate and unknown codes included, is handled as uncached: only pol_i[1:0] decides.
- R7: With dcache_en_i = 1, attribute codes 3'd4 to 3'd7 are accepted without any policy check.
- R8: An accepted request has rsp_accept_o = 1 and rsp_cause_o = 0. A rejected one has rsp_accept_o = 0 and a nonzero cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| xlat_code_i | input | 4 | Translation result, 0 = success, else the fault cause |
| perm_rd_i | input | 1 | Page grants read |
| perm_wr_i | input | 1 | Page grants write |
| attr_i | input | 3 | Page cache attribute code |
| dcache_en_i | input | 1 | Data cache is present |
| pol_i | input | 6 | Atomic policy word, three 2-bit fields |
| rsp_valid_o | output | 1 | Verdict valid pulse |
| rsp_accept_o | output | 1 | Access may proceed |
| rsp_cause_o | output | 4 | Exception cause, 0 on accept |

## Verification
The bench sets up requests that each trip more than one fault at once. Examples are a translation fault on a page with no rights, and missing rights on an isolate page. A design with the priority order wrong reports the later cause. Each policy field is made zero while the other two are left nonzero. A design that decodes the wrong field accepts where it should fault, or faults where it should accept. Requests without a data cache use write-back, isolate and unknown attribute codes. A design that still honours the attribute in that mode checks a different field, or faults an isolate page that should be accepted. An idle cycle after a request confirms that the valid pulse does not stretch.

// File: rtl/aac_pkg.sv
package aac_pkg;
  localparam int ATTR_W   = 3;
  localparam int CAUSE_W  = 4;
  localparam int FIELD_W  = 2;
  localparam int N_FIELDS = 3;
  localparam int POL_W    = FIELD_W * N_FIELDS;

  localparam logic [ATTR_W-1:0] ATTR_UNCACHED = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WTHRU    = 3'd1;
  localparam logic [ATTR_W-1:0] ATTR_WBACK    = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_ISOLATE  = 3'd3;

  typedef enum logic [1:0] {
    VERDICT_OK   = 2'd0,
    VERDICT_XLAT = 2'd1,
    VERDICT_PERM = 2'd2,
    VERDICT_ATTR = 2'd3
  } verdict_e;
endpackage

// File: rtl/aac_field_sel.sv
module aac_field_sel
  import aac_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = N_FIELDS,
  parameter int AW = ATTR_W
) (
  input  logic [FW*NF-1:0] pol_i,
  input  logic [AW-1:0]    attr_i,
  input  logic             dcache_en_i,
  output logic             attr_fault_o
);
  logic [AW-1:0] eff_attr;
  logic [NF-1:0] field_zero;
  logic [NF-1:0] field_hit;

  // Without a data cache every page behaves as uncached.
  assign eff_attr = dcache_en_i ? attr_i : ATTR_UNCACHED;

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign field_zero[g] = (pol_i[g*FW +: FW] == '0);
    assign field_hit[g]  = (eff_attr == AW'(g));
  end

  always_comb begin
    attr_fault_o = |(field_zero & field_hit);
    if (eff_attr == ATTR_ISOLATE) attr_fault_o = 1'b1;
  end

  always_comb begin
    assert_hit_onehot_R4: assert ($onehot0(field_hit));
  end
endmodule

// File: rtl/aac_decide.sv
module aac_decide
  import aac_pkg::*;
#(
  parameter int            CW           = CAUSE_W,
  parameter logic [CW-1:0] CAUSE_STPROT = 4'hD,
  parameter logic [CW-1:0] CAUSE_LSERR  = 4'h3
) (
  input  logic [CW-1:0] xlat_code_i,
  input  logic          perm_rd_i,
  input  logic          perm_wr_i,
  input  logic          attr_fault_i,
  output verdict_e      verdict_o,
  output logic [CW-1:0] cause_o
);
  always_comb begin
    if (xlat_code_i != '0) begin
      verdict_o = VERDICT_XLAT;
      cause_o   = xlat_code_i;
    end else if (!(perm_rd_i && perm_wr_i)) begin
      verdict_o = VERDICT_PERM;
      cause_o   = CAUSE_STPROT;
    end else if (attr_fault_i) begin
      verdict_o = VERDICT_ATTR;
      cause_o   = CAUSE_LSERR;
    end else begin
      verdict_o = VERDICT_OK;
      cause_o   = '0;
    end
  end

  always_comb begin
    assert_cause_nonzero_R8: assert ((verdict_o == VERDICT_OK) == (cause_o == '0));
  end
endmodule

// File: rtl/aac_checker.sv
module aac_checker
  import aac_pkg::*;
#(
  parameter int               AW           = ATTR_W,
  parameter int               CW           = CAUSE_W,
  parameter int               FW           = FIELD_W,
  parameter int               NF           = N_FIELDS,
  parameter logic [CAUSE_W-1:0] CAUSE_STPROT = 4'hD,
  parameter logic [CAUSE_W-1:0] CAUSE_LSERR  = 4'h3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [CW-1:0]    xlat_code_i,
  input  logic             perm_rd_i,
  input  logic             perm_wr_i,
  input  logic [AW-1:0]    attr_i,
  input  logic             dcache_en_i,
  input  logic [FW*NF-1:0] pol_i,
  output logic             rsp_valid_o,
  output logic             rsp_accept_o,
  output logic [CW-1:0]    rsp_cause_o
);
  logic          attr_fault;
  verdict_e      verdict;
  logic [CW-1:0] cause;

  aac_field_sel #(.FW(FW), .NF(NF), .AW(AW)) u_sel (
    .pol_i       (pol_i),
    .attr_i      (attr_i),
    .dcache_en_i (dcache_en_i),
    .attr_fault_o(attr_fault)
  );

  aac_decide #(.CW(CW), .CAUSE_STPROT(CW'(CAUSE_STPROT)), .CAUSE_LSERR(CW'(CAUSE_LSERR))) u_dec (
    .xlat_code_i (xlat_code_i),
    .perm_rd_i   (perm_rd_i),
    .perm_wr_i   (perm_wr_i),
    .attr_fault_i(attr_fault),
    .verdict_o   (verdict),
    .cause_o     (cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o  <= 1'b0;
      rsp_accept_o <= 1'b0;
      rsp_cause_o  <= '0;
    end else begin
      rsp_valid_o  <= req_i;
      rsp_accept_o <= req_i && (verdict == VERDICT_OK);
      rsp_cause_o  <= req_i ? cause : '0;
    end
  end

  assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rsp_valid_o);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!rsp_valid_o && !rsp_accept_o && rsp_cause_o == '0));
  assert_xlat_first_R2: assert property (@(posedge clk) disable iff (rst)
    (req_i && xlat_code_i != '0) |=> (!rsp_accept_o && rsp_cause_o == $past(xlat_code_i)));
  assert_perm_store_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i && xlat_code_i == '0 && !(perm_rd_i && perm_wr_i))
      |=> (!rsp_accept_o && rsp_cause_o == CW'(CAUSE_STPROT)));
  assert_isolate_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (req_i && xlat_code_i == '0 && perm_rd_i && perm_wr_i && dcache_en_i && attr_i == ATTR_ISOLATE)
      |=> (!rsp_accept_o && rsp_cause_o == CW'(CAUSE_LSERR)));
  assert_accept_clean_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_accept_o |-> (rsp_valid_o && rsp_cause_o == '0));
endmodule

// File: tb/aac_checker_tb.sv
module aac_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_i;
  logic [3:0] xlat_code_i;
  logic       perm_rd_i, perm_wr_i;
  logic [2:0] attr_i;
  logic       dcache_en_i;
  logic [5:0] pol_i;
  logic       rsp_valid_o, rsp_accept_o;
  logic [3:0] rsp_cause_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aac_checker u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .xlat_code_i(xlat_code_i),
    .perm_rd_i(perm_rd_i), .perm_wr_i(perm_wr_i), .attr_i(attr_i),
    .dcache_en_i(dcache_en_i), .pol_i(pol_i), .rsp_valid_o(rsp_valid_o),
    .rsp_accept_o(rsp_accept_o), .rsp_cause_o(rsp_cause_o)
  );

  // {req_no[3:0], xlat[3:0], rd, wr, attr[2:0], dcache, pol[5:0], exp_acc, exp_cause[3:0]}
  localparam logic [24:0] VECS [0:NV-1] = '{
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 6'b000001, 1'b1, 4'h0}, // R4 uncached ok
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 6'b111100, 1'b0, 4'h3}, // R4 uncached field zero
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd1, 1'b1, 6'b000100, 1'b1, 4'h0}, // R4 write-through ok
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd1, 1'b1, 6'b110011, 1'b0, 4'h3}, // R4 write-through zero
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd2, 1'b1, 6'b100000, 1'b1, 4'h0}, // R4 write-back ok
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd2, 1'b1, 6'b001111, 1'b0, 4'h3}, // R4 write-back zero
    {4'd5, 4'h0, 1'b1, 1'b1, 3'd3, 1'b1, 6'b111111, 1'b0, 4'h3}, // R5 isolate
    {4'd7, 4'h0, 1'b1, 1'b1, 3'd5, 1'b1, 6'b000000, 1'b1, 4'h0}, // R7 unknown attr
    {4'd3, 4'h0, 1'b1, 1'b0, 3'd0, 1'b1, 6'b111111, 1'b0, 4'hD}, // R3 no write
    {4'd3, 4'h0, 1'b0, 1'b1, 3'd3, 1'b1, 6'b000000, 1'b0, 4'hD}, // R3 beats isolate
    {4'd3, 4'h0, 1'b0, 1'b0, 3'd0, 1'b1, 6'b111111, 1'b0, 4'hD}, // R3 no rights
    {4'd2, 4'h6, 1'b0, 1'b0, 3'd3, 1'b1, 6'b000000, 1'b0, 4'h6}, // R2 beats all
    {4'd2, 4'h9, 1'b1, 1'b1, 3'd0, 1'b1, 6'b111111, 1'b0, 4'h9}, // R2 clean page
    {4'd6, 4'h0, 1'b1, 1'b1, 3'd2, 1'b0, 6'b000011, 1'b1, 4'h0}, // R6 wb as uncached
    {4'd6, 4'h0, 1'b1, 1'b1, 3'd2, 1'b0, 6'b111100, 1'b0, 4'h3}, // R6 wb as uncached zero
    {4'd6, 4'h0, 1'b1, 1'b1, 3'd3, 1'b0, 6'b000010, 1'b1, 4'h0}, // R6 isolate as uncached
    {4'd6, 4'h0, 1'b1, 1'b1, 3'd7, 1'b0, 6'b000000, 1'b0, 4'h3}, // R6 unknown as uncached
    {4'd4, 4'h0, 1'b1, 1'b1, 3'd1, 1'b1, 6'b000011, 1'b0, 4'h3}  // R4 wt ignores [1:0]
  };

  task automatic check(input string tag, input logic v, input logic a, input logic [3:0] c,
                       input logic ev, input logic ea, input logic [3:0] ec);
    n_checks++;
    if (v !== ev || a !== ea || c !== ec) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b accept=%0b cause=%h, expected valid=%0b accept=%0b cause=%h",
               tag, v, a, c, ev, ea, ec);
    end
  endtask

  task automatic drive(input logic rq, input logic [3:0] x, input logic rd, input logic wr,
                       input logic [2:0] at, input logic dc, input logic [5:0] p);
    req_i = rq; xlat_code_i = x; perm_rd_i = rd; perm_wr_i = wr;
    attr_i = at; dcache_en_i = dc; pol_i = p;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 6'b111111);
    repeat (3) @(negedge clk);
    check("R1 reset", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b0, 1'b0, 4'h0);
    rst = 1'b0;
    drive(1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 1'b1, 6'b0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VECS[i];
      drive(1'b1, v[20:17], v[16], v[15], v[14:12], v[11], v[10:5]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", v[24:21], i), rsp_valid_o, rsp_accept_o, rsp_cause_o,
            1'b1, v[4], v[3:0]);
    end

    // R1: idle cycle after a request, pulse must not stretch
    drive(1'b0, 4'h7, 1'b1, 1'b1, 3'd0, 1'b1, 6'b111111);
    @(negedge clk);
    check("R1 idle", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b0, 1'b0, 4'h0);

    // R8: accept after a reject, cause returns to 0
    drive(1'b1, 4'hD, 1'b0, 1'b0, 3'd0, 1'b1, 6'b000001);
    @(negedge clk);
    check("R2 back-to-back", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b1, 1'b0, 4'hD);
    drive(1'b1, 4'h0, 1'b1, 1'b1, 3'd0, 1'b1, 6'b000001);
    @(negedge clk);
    check("R8 accept clean", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b1, 1'b1, 4'h0);

    // R1: reset while a request is presented
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b0, 1'b0, 4'h0);
    rst = 1'b0;
    drive(1'b0, 4'h0, 1'b0, 1'b0, 3'd0, 1'b1, 6'b0);
    @(negedge clk);
    check("R1 after reset", rsp_valid_o, rsp_accept_o, rsp_cause_o, 1'b0, 1'b0, 4'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule